// File: doc/BRIEF.md
# Byte-Lane Static Memory Model

A clocked, synthesizable stand-in for a 16-bit-wide asynchronous static memory with active-low control pins. Each system clock samples chip select, write enable, output enable, the two byte enables, the 18-bit address and the 16-bit write word. A small state machine turns each sample into one of four operating modes and reports it on a 2-bit status output.

Reads return the stored word on a 16-bit data output. A two-bit drive-enable output takes the place of tri-state pads: bit 0 covers data bits 7:0 and bit 1 covers bits 15:8. A write is held open for as long as the sampled pins request one. The data is stored only when the cycle ends, which happens at the first sampled rising edge of write enable or chip select. The storage depth is set by a parameter. When it is made smaller than the address space, the upper address bits are ignored and addresses alias.

The state machine has four states, each named after its mode: ST_STANDBY (code 0), ST_OUT_OFF (code 1), ST_READ (code 2) and ST_WRITE (code 3). On every clock it moves to the state decoded from the pins sampled at that edge, so any state can move to any other. The only transition with a side effect is the write release, which leaves ST_WRITE because the sampled chip select or write enable is high. The commit happens on that transition.

Top module: `sram_lane_model`

## Requirements
- R1: Words are 16 bits wide and the address is 18 bits. Only the low MEM_AW address bits select a word, so two addresses that differ only above bit MEM_AW-1 reach the same word.
- R2: With chip select high, or with both byte enables high, the mode code is 0 (standby). Both drive-enable bits are 0 and nothing is written.
- R3: With chip select low, write enable high, output enable high and at least one byte enable low, the mode code is 1 (output disable). Both drive-enable bits are 0.
- R4: With chip select low, write enable high, output enable low and at least one byte enable low, the mode code is 2 (read). Drive-enable bit k is 1 exactly when that lane's byte enable is low. A driven lane carries the stored byte and an undriven lane reads as 0.
- R5: With chip select low, write enable low and at least one byte enable low, the mode code is 3 (write). Both drive-enable bits are 0 whatever output enable is.
- R6: A write cycle that ends because the sampled write enable goes high stores the address, data and byte enables of the last write-mode sample. Address or data changes earlier in the cycle have no effect.
- R7: A write cycle that ends because the sampled chip select goes high, with write enable still low, stores the data in the same way as R6.
- R8: The lower byte enable (lane 0) controls bits 7:0 and the upper byte enable (lane 1) controls bits 15:8. A lane whose enable was high in the committing sample keeps its old contents.
- R9: The outputs show the pins sampled at the most recent clock edge, one cycle after the pins change. While reset is asserted the mode is 0 and both drive-enable bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower byte enable (bits 7:0), active low |
| ub_n | input | 1 | Upper byte enable (bits 15:8), active low |
| addr | input | ADDR_W (18) | Word address |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Read data, 0 on undriven lanes |
| rd_oe | output | DATA_W/8 (2) | Per-lane drive enable: bit 0 lower, bit 1 upper |
| mode | output | 2 | 0 standby, 1 output disable, 2 read, 3 write |

## Verification
The assertions assume that every pin is a clean, already-synchronous level at each clock edge. They also assume that reset holds for at least one edge before the first access. The bench meets both by changing every pin only on the falling clock edge, well away from the sampling edge, and by keeping reset low for several cycles at start. The storage is not reset, so the bench writes every word of a 16-word configuration before it reads anything back. Every read is compared against a model that the bench keeps word by word from the byte-enable rules.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [1:0] {
        ST_STANDBY = 2'd0,
        ST_OUT_OFF = 2'd1,
        ST_READ    = 2'd2,
        ST_WRITE   = 2'd3
    } sram_state_e;

    // Mode implied by one sample of the control pins; all-high lanes idle the part.
    function automatic sram_state_e decode_pins(
        input logic cs_n,
        input logic we_n,
        input logic oe_n,
        input logic all_lanes_off
    );
        if (cs_n || all_lanes_off) return ST_STANDBY;
        else if (!we_n)            return ST_WRITE;
        else if (!oe_n)            return ST_READ;
        else                       return ST_OUT_OFF;
    endfunction

endpackage

// File: rtl/sram_pin_sampler.sv
module sram_pin_sampler #(
    parameter int AW    = 10,
    parameter int DW    = 16,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_in,
    input  logic [DW-1:0]    data_in,
    input  logic [LANES-1:0] be_n_in,
    output logic [AW-1:0]    held_addr,
    output logic [DW-1:0]    held_data,
    output logic [LANES-1:0] held_be_n
);

    // One register stage: the "previous sample" seen by the edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr <= '0;
            held_data <= '0;
            held_be_n <= '1;
        end else begin
            held_addr <= addr_in;
            held_data <= data_in;
            held_be_n <= be_n_in;
        end
    end

endmodule

// File: rtl/sram_mode_fsm.sv
module sram_mode_fsm
    import sram_lane_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [LANES-1:0] be_n,
    input  logic [LANES-1:0] held_be_n,
    output sram_state_e      state,
    output logic             commit,
    output logic [LANES-1:0] lane_we,
    output logic [LANES-1:0] lane_rd
);

    sram_state_e st_q;
    sram_state_e st_d;

    assign st_d  = decode_pins(cs_n, we_n, oe_n, &be_n);
    assign state = st_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_STANDBY;
        else        st_q <= st_d;
    end

    // Outputs: the write release is seen as a rise of cs_n or we_n against
    // the sample held in ST_WRITE.
    always_comb begin
        commit  = 1'b0;
        lane_we = '0;
        lane_rd = '0;
        unique case (st_q)
            ST_STANDBY: ;
            ST_OUT_OFF: ;
            ST_READ: begin
                lane_rd = ~held_be_n;
            end
            ST_WRITE: begin
                commit  = cs_n | we_n;
                lane_we = commit ? ~held_be_n : '0;
            end
            default: ;
        endcase
    end

    // R6/R7: after a release the machine has left the write state
    a_r6_release_leaves_write: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> st_q != ST_WRITE);

    // R5: the write state is only held with a lane enabled in the held sample
    a_r5_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
        st_q == ST_WRITE |-> !(&held_be_n));

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
    parameter int AW = 10,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wr_byte,
    input  logic          drive,
    output logic [W-1:0]  rd_byte,
    output logic          rd_en
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[addr] <= wr_byte;
    end

    assign rd_byte = drive ? store[addr] : '0;
    assign rd_en   = drive;

endmodule

// File: rtl/sram_lane_model.sv
module sram_lane_model
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16,
    parameter int MEM_AW = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic                lb_n,
    input  logic                ub_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [DATA_W/8-1:0] rd_oe,
    output logic [1:0]          mode
);

    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0]  be_n;
    logic [MEM_AW-1:0] held_addr;
    logic [DATA_W-1:0] held_data;
    logic [LANES-1:0]  held_be_n;
    logic [LANES-1:0]  lane_we;
    logic [LANES-1:0]  lane_rd;
    logic              commit;
    sram_state_e       state;

    // Lane 0 is the lower byte, lane 1 the upper byte
    assign be_n = {ub_n, lb_n};

    generate
        if (MEM_AW < ADDR_W) begin : g_alias
            logic unused_addr_hi;
            assign unused_addr_hi = ^addr[ADDR_W-1:MEM_AW];
        end
    endgenerate

    sram_pin_sampler #(.AW(MEM_AW), .DW(DATA_W), .LANES(LANES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_in   (addr[MEM_AW-1:0]),
        .data_in   (wdata),
        .be_n_in   (be_n),
        .held_addr (held_addr),
        .held_data (held_data),
        .held_be_n (held_be_n)
    );

    sram_mode_fsm #(.LANES(LANES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .be_n      (be_n),
        .held_be_n (held_be_n),
        .state     (state),
        .commit    (commit),
        .lane_we   (lane_we),
        .lane_rd   (lane_rd)
    );

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_lane
            sram_byte_lane #(.AW(MEM_AW), .W(8)) u_lane (
                .clk     (clk),
                .wr_en   (lane_we[k]),
                .addr    (held_addr),
                .wr_byte (held_data[8*k +: 8]),
                .drive   (lane_rd[k]),
                .rd_byte (rdata[8*k +: 8]),
                .rd_en   (rd_oe[k])
            );
        end
    endgenerate

    assign mode = state;

    // R2: standby drives nothing
    a_r2_standby_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_STANDBY |-> rd_oe == '0);

    // R3: output disable drives nothing
    a_r3_outoff_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_OUT_OFF |-> rd_oe == '0);

    // R5: no lane is driven while writing
    a_r5_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WRITE |-> rd_oe == '0);

    // R4: a driven lane implies read mode
    a_r4_drive_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe != '0 |-> state == ST_READ);

    // R9: reset leaves the outputs idle on the following cycle
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (mode == 2'd0 && rd_oe == '0));

endmodule

// File: tb/sram_lane_model_bench.sv
module sram_lane_model_bench;

    localparam int CLK_P = 10;
    localparam int AW    = 4;
    localparam int WORDS = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, lb_n = 1'b1, ub_n = 1'b1;
    logic [17:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  rd_oe;
    logic [1:0]  mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [15:0] exp_mem [WORDS];

    always #(CLK_P/2) clk = ~clk;

    sram_lane_model #(.ADDR_W(18), .DATA_W(16), .MEM_AW(AW)) u_sram_lane_model (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
        .lb_n(lb_n), .ub_n(ub_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rd_oe(rd_oe), .mode(mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive pins at a falling edge, return at the next falling edge (one sample later).
    task automatic step(input logic c, input logic w, input logic o, input logic l,
                        input logic u, input logic [17:0] a, input logic [15:0] d);
        cs_n = c; we_n = w; oe_n = o; lb_n = l; ub_n = u; addr = a; wdata = d;
        @(negedge clk);
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'(a * 16'h1111) ^ 16'hA5C3;
    endfunction

    task automatic model_write(input logic [17:0] a, input logic l, input logic u,
                               input logic [15:0] d);
        if (!l) exp_mem[a[AW-1:0]][7:0]  = d[7:0];
        if (!u) exp_mem[a[AW-1:0]][15:8] = d[15:8];
    endtask

    // One write cycle; by_cs chooses which pin ends it.
    task automatic wr(input logic [17:0] a, input logic [15:0] d, input logic l,
                      input logic u, input logic o, input bit by_cs);
        step(1'b0, 1'b0, o, l, u, a, d);
        chk("R5 write mode", mode, 2'd3);
        chk("R5 no drive while writing", rd_oe, 2'b00);
        if (by_cs) begin
            step(1'b1, 1'b0, o, l, u, a, d);
            chk("R7 standby after cs release", mode, 2'd0);
        end else begin
            step(1'b0, 1'b1, 1'b1, l, u, a, d);
            chk("R3 output disable after we release", mode, 2'd1);
            chk("R3 no drive", rd_oe, 2'b00);
        end
        model_write(a, l, u, d);
    endtask

    task automatic rd(input logic [17:0] a, input logic l, input logic u, input string tag);
        logic [15:0] e;
        step(1'b0, 1'b1, 1'b0, l, u, a, 16'h0);
        if (l && u) begin
            chk("R2 standby by byte enables", mode, 2'd0);
            chk("R2 no drive", rd_oe, 2'b00);
        end else begin
            e = exp_mem[a[AW-1:0]];
            if (l) e[7:0]  = 8'h00;
            if (u) e[15:8] = 8'h00;
            chk("R4 read mode", mode, 2'd2);
            chk("R4 lane drive", rd_oe, {~u, ~l});
            chk(tag, rdata, e);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R9 reset mode", mode, 2'd0);
        chk("R9 reset drive", rd_oe, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: fill every word with both lanes, released by write enable
        for (int a = 0; a < WORDS; a++) wr(18'(a), pat(a), 1'b0, 1'b0, 1'b1, 1'b0);
        for (int a = 0; a < WORDS; a++) rd(18'(a), 1'b0, 1'b0, "R6 full word readback");

        // R7/R8: byte-lane writes released by chip select, output enable low (R5)
        for (int a = 0; a < WORDS; a++) begin
            logic l = (a % 3 == 1);
            logic u = (a % 3 == 0);
            wr(18'(a), ~pat(a) ^ 16'(a), l, u, 1'b0, 1'b1);
        end
        for (int a = 0; a < WORDS; a++)
            for (int m = 0; m < 4; m++)
                rd(18'(a), m[0], m[1], "R8 lane-masked readback");

        // R9: one-cycle latency, the mode follows the new pins after one edge
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 18'd2, 16'h0);
        chk("R9 output disable sample", mode, 2'd1);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 18'd2, 16'h0);
        chk("R9 read after one edge", mode, 2'd2);

        // R1: aliasing above MEM_AW
        wr(18'd3 + 18'(WORDS * 5), 16'h5AA5, 1'b0, 1'b0, 1'b1, 1'b0);
        rd(18'd3, 1'b0, 1'b0, "R1 alias readback");
        wr(18'h3FFFF, 16'hC33C, 1'b0, 1'b0, 1'b1, 1'b0);
        rd(18'(WORDS - 1), 1'b0, 1'b0, "R1 top address alias");

        // R6: address and data moved inside one write cycle, last sample wins
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 18'd5, 16'h1234);
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 18'd6, 16'hBEEF);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 18'd6, 16'hBEEF);
        model_write(18'd6, 1'b0, 1'b0, 16'hBEEF);
        rd(18'd5, 1'b0, 1'b0, "R6 earlier address untouched");
        rd(18'd6, 1'b0, 1'b0, "R6 last sample committed");

        // R2: write enable low with chip select high stores nothing
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'd7, 16'hDEAD);
        chk("R2 standby by chip select", mode, 2'd0);
        chk("R2 no drive", rd_oe, 2'b00);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'd7, 16'hDEAD);
        rd(18'd7, 1'b0, 1'b0, "R2 no write in standby");

        // R3: output disable leaves memory unchanged
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 18'd8, 16'hFFFF);
        chk("R3 output disable mode", mode, 2'd1);
        rd(18'd8, 1'b0, 1'b0, "R3 memory unchanged");

        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 18'd0, 16'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule